// File: doc/BRIEF.md
# Exception Qualification and Vector Selection Unit

This unit sits beside the pipeline of a small in-order processor core. Every cycle it gathers the exception conditions raised by the decode, execute and address-translation stages, plus a critical-interrupt pin, a decrementer sign bit and a set of instruction-address breakpoint registers. It checks each condition against the enable bits of the current machine status. When one or more conditions survive, it picks one by a fixed priority and raises a taken strobe together with a 20-bit vector offset, all in the same cycle.

For program exceptions it also produces a cause code, one bit per sub-cause, for the context-save logic to store. The unit gives the next value of the external-interrupt enable, which is forced low whenever an interrupt is taken.

The decrementer is the only source with memory. A 0-to-1 transition of its most significant bit is latched as pending. The pending flag stays set until the decrementer interrupt is taken or software clears it. Every other source is a single-cycle pulse or a level that is judged only in the cycle it is present.

Top module: `exc_vector_unit`

## Requirements
- R1: `take_o` is high in a cycle exactly when at least one qualified condition exists. `vector_o` then carries the chosen source's offset:
  - critical 0x00A00
  - breakpoint 0x01300
  - instruction translation miss 0x01000
  - load translation miss 0x01100
  - store translation miss 0x01200
  - program 0x00700
  - floating-point unavailable 0x00800
  - system call 0x00C00
  - decrementer 0x00900
  - performance monitor 0x00F00
  - trace 0x00D00

  Priority runs in the listed order, highest first. Offsets 0x00B00–0x00BFF and 0x00E00 never appear.
- R2: A program exception comes from any of three events: `fp_done_i` with `fpx_sum_i`=1 and a nonzero `st_fpx_mode_i`, `illegal_i`, or `trap_i`. When the program vector is taken, `cause_o` bit 0 flags floating-point enabled, bit 1 illegal, bit 2 privileged and bit 3 trap. Several bits may be set together.
- R3: A privileged program exception (cause bit 2) comes from either of two events while `st_user_i`=1: `priv_op_i`, or `spr_move_i` with `spr_hi_i`=1. When `st_user_i`=0 neither event raises anything.
- R4: `fp_op_i` raises floating-point unavailable only while `st_fpu_avail_i`=0.
- R5: A 0-to-1 change of `dec_msb_i` between consecutive cycles makes the decrementer pending. It is taken only in a cycle with `st_ext_en_i`=1.
- R6: A pending decrementer condition that is not taken stays pending into later cycles. It is cleared when the decrementer vector is taken or when `dec_clr_i` is high.
- R7: `crit_i` with `st_crit_en_i`=1 is always taken, with vector 0x00A00. With `st_crit_en_i`=0 the pin has no effect.
- R8: `complete_i` raises trace when `st_step_i`=1, or when `branch_i`=1 and `st_br_trace_i`=1.
- R9: Breakpoint k matches under two conditions: its enable `bkpt_en_i[k]` is 1, and its 30-bit word address `bkpt_addr_i[30*k +: 30]` equals `next_pc_i`. A disabled or unequal breakpoint has no effect.
- R10: A store translation miss comes from either of two events: `st_miss_i`, or `st_hit_i` with `pte_chg_i`=0. A store hit with `pte_chg_i`=1 raises nothing.
- R11: `ext_en_next_o` is 0 in any cycle with `take_o`=1. Otherwise it equals `st_ext_en_i`.
- R12: `imiss_i`, `ld_miss_i`, `syscall_i` and `pm_ovf_i` raise their own vectors with no enable gating.
- R13: When no condition is raised, `take_o`=0 and both `vector_o` and `cause_o` are zero. This includes the reset state with idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_ext_en_i | input | 1 | Status: external/decrementer interrupt enable |
| st_crit_en_i | input | 1 | Status: critical interrupt enable |
| st_user_i | input | 1 | Status: user (unprivileged) mode |
| st_fpu_avail_i | input | 1 | Status: floating-point unit available |
| st_fpx_mode_i | input | 2 | Status: floating-point exception mode bits |
| st_step_i | input | 1 | Status: single-step trace |
| st_br_trace_i | input | 1 | Status: branch trace |
| fpx_sum_i | input | 1 | Floating-point enabled-exception summary flag |
| fp_done_i | input | 1 | Pulse: FP instruction or FP status move completed |
| illegal_i | input | 1 | Pulse: illegal opcode |
| trap_i | input | 1 | Pulse: trap condition met |
| priv_op_i | input | 1 | Pulse: privileged instruction executed |
| spr_move_i | input | 1 | Pulse: move to/from special register |
| spr_hi_i | input | 1 | Special-register number MSB of that move |
| fp_op_i | input | 1 | Pulse: any floating-point instruction |
| syscall_i | input | 1 | Pulse: system call |
| complete_i | input | 1 | Pulse: instruction completed |
| branch_i | input | 1 | Completing instruction is a branch |
| pm_ovf_i | input | 1 | Pulse: performance counter overflow |
| imiss_i | input | 1 | Pulse: instruction translation miss |
| ld_miss_i | input | 1 | Pulse: load translation miss |
| st_miss_i | input | 1 | Pulse: store translation miss |
| st_hit_i | input | 1 | Pulse: store translation hit |
| pte_chg_i | input | 1 | Change bit of the hit page entry |
| crit_i | input | 1 | Critical interrupt pin |
| dec_msb_i | input | 1 | Decrementer most significant bit |
| dec_clr_i | input | 1 | Software clear of pending decrementer |
| bkpt_addr_i | input | NUM_BKPT*30 | Breakpoint word addresses |
| bkpt_en_i | input | NUM_BKPT | Breakpoint enables |
| next_pc_i | input | 30 | Word address of next instruction to complete |
| take_o | output | 1 | Interrupt taken this cycle |
| vector_o | output | 20 | Vector offset |
| cause_o | output | 4 | Program-exception cause bits |
| ext_en_next_o | output | 1 | Next value of the external enable |

## Verification
Apart from the decrementer tracker, the decision is combinational, so a wrong enable term or priority order shows at `vector_o` in the same cycle the stimulus is applied. A corrupted edge detector or pending flag in the decrementer tracker is the only state that can hide. It surfaces one or more cycles later, as a missing 0x00900 take once the enable rises, or as a spurious one after a software clear. The directed sequences toggle the enable and the clear around a latched edge so that such an error appears within three cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_SRC = 11;
  localparam int VEC_W   = 20;
  localparam int CAUSE_W = 4;

  // index order is priority order, 0 highest
  localparam int SRC_CRIT  = 0;
  localparam int SRC_BKPT  = 1;
  localparam int SRC_IMISS = 2;
  localparam int SRC_LMISS = 3;
  localparam int SRC_SMISS = 4;
  localparam int SRC_PROG  = 5;
  localparam int SRC_FPU   = 6;
  localparam int SRC_SC    = 7;
  localparam int SRC_DEC   = 8;
  localparam int SRC_PM    = 9;
  localparam int SRC_TRACE = 10;

  localparam int CZ_FPX  = 0;
  localparam int CZ_ILL  = 1;
  localparam int CZ_PRIV = 2;
  localparam int CZ_TRAP = 3;

  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    case (idx)
      SRC_CRIT:  return 20'h00A00;
      SRC_BKPT:  return 20'h01300;
      SRC_IMISS: return 20'h01000;
      SRC_LMISS: return 20'h01100;
      SRC_SMISS: return 20'h01200;
      SRC_PROG:  return 20'h00700;
      SRC_FPU:   return 20'h00800;
      SRC_SC:    return 20'h00C00;
      SRC_DEC:   return 20'h00900;
      SRC_PM:    return 20'h00F00;
      SRC_TRACE: return 20'h00D00;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_cond.sv
module exc_cond
  import exc_pkg::*;
(
  input  logic               st_crit_en_i,
  input  logic               st_user_i,
  input  logic               st_fpu_avail_i,
  input  logic [1:0]         st_fpx_mode_i,
  input  logic               st_step_i,
  input  logic               st_br_trace_i,
  input  logic               fpx_sum_i,
  input  logic               fp_done_i,
  input  logic               illegal_i,
  input  logic               trap_i,
  input  logic               priv_op_i,
  input  logic               spr_move_i,
  input  logic               spr_hi_i,
  input  logic               fp_op_i,
  input  logic               syscall_i,
  input  logic               complete_i,
  input  logic               branch_i,
  input  logic               pm_ovf_i,
  input  logic               imiss_i,
  input  logic               ld_miss_i,
  input  logic               st_miss_i,
  input  logic               st_hit_i,
  input  logic               pte_chg_i,
  input  logic               crit_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o          = '0;
    cause_o[CZ_FPX]  = fp_done_i & fpx_sum_i & (|st_fpx_mode_i);
    cause_o[CZ_ILL]  = illegal_i;
    cause_o[CZ_PRIV] = st_user_i & (priv_op_i | (spr_move_i & spr_hi_i));
    cause_o[CZ_TRAP] = trap_i;
  end

  always_comb begin
    req_o            = '0;
    req_o[SRC_CRIT]  = crit_i & st_crit_en_i;
    req_o[SRC_IMISS] = imiss_i;
    req_o[SRC_LMISS] = ld_miss_i;
    // a store hit on a clean page must still trap to set the change bit
    req_o[SRC_SMISS] = st_miss_i | (st_hit_i & ~pte_chg_i);
    req_o[SRC_PROG]  = |cause_o;
    req_o[SRC_FPU]   = fp_op_i & ~st_fpu_avail_i;
    req_o[SRC_SC]    = syscall_i;
    req_o[SRC_PM]    = pm_ovf_i;
    req_o[SRC_TRACE] = complete_i & (st_step_i | (branch_i & st_br_trace_i));
  end
endmodule

// File: rtl/exc_dec_track.sv
module exc_dec_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dec_msb_i,
  input  logic ext_en_i,
  input  logic taken_i,
  input  logic clr_i,
  output logic req_o
);
  logic msb_q, pend_q, cond;

  assign cond  = pend_q | (dec_msb_i & ~msb_q);
  assign req_o = cond & ext_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      msb_q  <= dec_msb_i;
      pend_q <= cond & ~taken_i & ~clr_i;
    end
  end
endmodule

// File: rtl/exc_bkpt_match.sv
module exc_bkpt_match #(
  parameter int NUM_BKPT = 2,
  parameter int WA_W     = 30
) (
  input  logic [NUM_BKPT*WA_W-1:0] addr_i,
  input  logic [NUM_BKPT-1:0]      en_i,
  input  logic [WA_W-1:0]          pc_i,
  output logic                     hit_o
);
  logic [NUM_BKPT-1:0] hit;

  for (genvar k = 0; k < NUM_BKPT; k++) begin : g_cmp
    assign hit[k] = en_i[k] & (addr_i[k*WA_W +: WA_W] == pc_i);
  end

  assign hit_o = |hit;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] sel_o,
  output logic               take_o,
  output logic [VEC_W-1:0]   vector_o
);
  always_comb begin
    sel_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    vector_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_o[i]) vector_o = vector_o | src_vector(i);
    end
  end

  assign take_o = |req_i;
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int NUM_BKPT = 2,
  parameter int ADDR_W   = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           st_ext_en_i,
  input  logic                           st_crit_en_i,
  input  logic                           st_user_i,
  input  logic                           st_fpu_avail_i,
  input  logic [1:0]                     st_fpx_mode_i,
  input  logic                           st_step_i,
  input  logic                           st_br_trace_i,
  input  logic                           fpx_sum_i,
  input  logic                           fp_done_i,
  input  logic                           illegal_i,
  input  logic                           trap_i,
  input  logic                           priv_op_i,
  input  logic                           spr_move_i,
  input  logic                           spr_hi_i,
  input  logic                           fp_op_i,
  input  logic                           syscall_i,
  input  logic                           complete_i,
  input  logic                           branch_i,
  input  logic                           pm_ovf_i,
  input  logic                           imiss_i,
  input  logic                           ld_miss_i,
  input  logic                           st_miss_i,
  input  logic                           st_hit_i,
  input  logic                           pte_chg_i,
  input  logic                           crit_i,
  input  logic                           dec_msb_i,
  input  logic                           dec_clr_i,
  input  logic [NUM_BKPT*(ADDR_W-2)-1:0] bkpt_addr_i,
  input  logic [NUM_BKPT-1:0]            bkpt_en_i,
  input  logic [ADDR_W-3:0]              next_pc_i,
  output logic                           take_o,
  output logic [VEC_W-1:0]               vector_o,
  output logic [CAUSE_W-1:0]             cause_o,
  output logic                           ext_en_next_o
);
  localparam int WA_W = ADDR_W - 2;

  logic [NUM_SRC-1:0] cond_req, req, sel;
  logic [CAUSE_W-1:0] prog_cause;
  logic               dec_req, bk_hit;

  exc_cond u_cond (
    .st_crit_en_i  (st_crit_en_i),
    .st_user_i     (st_user_i),
    .st_fpu_avail_i(st_fpu_avail_i),
    .st_fpx_mode_i (st_fpx_mode_i),
    .st_step_i     (st_step_i),
    .st_br_trace_i (st_br_trace_i),
    .fpx_sum_i     (fpx_sum_i),
    .fp_done_i     (fp_done_i),
    .illegal_i     (illegal_i),
    .trap_i        (trap_i),
    .priv_op_i     (priv_op_i),
    .spr_move_i    (spr_move_i),
    .spr_hi_i      (spr_hi_i),
    .fp_op_i       (fp_op_i),
    .syscall_i     (syscall_i),
    .complete_i    (complete_i),
    .branch_i      (branch_i),
    .pm_ovf_i      (pm_ovf_i),
    .imiss_i       (imiss_i),
    .ld_miss_i     (ld_miss_i),
    .st_miss_i     (st_miss_i),
    .st_hit_i      (st_hit_i),
    .pte_chg_i     (pte_chg_i),
    .crit_i        (crit_i),
    .req_o         (cond_req),
    .cause_o       (prog_cause)
  );

  exc_dec_track u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_msb_i(dec_msb_i),
    .ext_en_i (st_ext_en_i),
    .taken_i  (sel[SRC_DEC]),
    .clr_i    (dec_clr_i),
    .req_o    (dec_req)
  );

  exc_bkpt_match #(
    .NUM_BKPT(NUM_BKPT),
    .WA_W    (WA_W)
  ) u_bkpt (
    .addr_i(bkpt_addr_i),
    .en_i  (bkpt_en_i),
    .pc_i  (next_pc_i),
    .hit_o (bk_hit)
  );

  always_comb begin
    req           = cond_req;
    req[SRC_DEC]  = dec_req;
    req[SRC_BKPT] = bk_hit;
  end

  exc_arbiter u_arb (
    .req_i   (req),
    .sel_o   (sel),
    .take_o  (take_o),
    .vector_o(vector_o)
  );

  assign cause_o       = sel[SRC_PROG] ? prog_cause : '0;
  assign ext_en_next_o = st_ext_en_i & ~take_o;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               st_ext_en_i,
  input logic               st_crit_en_i,
  input logic               crit_i,
  input logic               take_o,
  input logic [VEC_W-1:0]   vector_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               ext_en_next_o
);
  assert_vec_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vector_o[7:0] == 8'h00 && vector_o >= 20'h00700 && vector_o <= 20'h01300
                && vector_o != 20'h00B00 && vector_o != 20'h00E00));

  assert_prog_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vector_o == 20'h00700) |-> cause_o != '0);

  assert_cause_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_o && vector_o == 20'h00700) |-> cause_o == '0);

  assert_dec_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vector_o == 20'h00900) |-> st_ext_en_i);

  assert_crit_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_i && st_crit_en_i) |-> (take_o && vector_o == 20'h00A00));

  assert_ee_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ext_en_next_o);

  assert_ee_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (ext_en_next_o == st_ext_en_i));

  assert_idle_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> vector_o == '0);
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (.*);

// File: tb/tb_exc_vector_unit.sv
module tb_exc_vector_unit;
  localparam int NB = 2;
  localparam int WA = 30;

  logic clk = 0, rst_ni = 0;
  logic ee, ce, usr, fpa, st_step, brt, fsum, fpd, ill, trp, pop, smv, shi, fop, sc;
  logic cmp, br, pmo, im, lm, sm, sh, chg, crit, dmsb, dclr;
  logic [1:0] fmode;
  logic [NB*WA-1:0] baddr;
  logic [NB-1:0] ben;
  logic [WA-1:0] pc;
  logic take;
  logic [19:0] vec;
  logic [3:0] cause;
  logic een;

  int n_run = 0, n_fail = 0;
  logic m_prev = 0, m_pend = 0;

  always #4 clk = ~clk;

  exc_vector_unit #(.NUM_BKPT(NB), .ADDR_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .st_ext_en_i(ee), .st_crit_en_i(ce), .st_user_i(usr),
    .st_fpu_avail_i(fpa), .st_fpx_mode_i(fmode), .st_step_i(st_step), .st_br_trace_i(brt),
    .fpx_sum_i(fsum), .fp_done_i(fpd), .illegal_i(ill), .trap_i(trp), .priv_op_i(pop),
    .spr_move_i(smv), .spr_hi_i(shi), .fp_op_i(fop), .syscall_i(sc), .complete_i(cmp),
    .branch_i(br), .pm_ovf_i(pmo), .imiss_i(im), .ld_miss_i(lm), .st_miss_i(sm),
    .st_hit_i(sh), .pte_chg_i(chg), .crit_i(crit), .dec_msb_i(dmsb), .dec_clr_i(dclr),
    .bkpt_addr_i(baddr), .bkpt_en_i(ben), .next_pc_i(pc),
    .take_o(take), .vector_o(vec), .cause_o(cause), .ext_en_next_o(een)
  );

  task automatic idle();
    {ee, ce, usr, fpa, st_step, brt, fsum, fpd, ill, trp, pop, smv, shi, fop, sc} = '0;
    {cmp, br, pmo, im, lm, sm, sh, chg, crit, dmsb, dclr} = '0;
    fmode = '0; baddr = '0; ben = '0; pc = '0;
    fpa = 1'b1;
  endtask

  // expected outputs from the requirement text
  task automatic model(output logic tk, output logic [19:0] v, output logic [3:0] c,
                       output logic dec_taken);
    logic [3:0] pc_cause;
    logic bk, rise;
    bk = 1'b0;
    for (int k = 0; k < NB; k++)
      if (ben[k] && baddr[k*WA +: WA] == pc) bk = 1'b1;
    pc_cause = {trp, usr & (pop | (smv & shi)), ill, fpd & fsum & (fmode != 2'b00)};
    rise = dmsb & ~m_prev;
    c = 4'h0; dec_taken = 1'b0; tk = 1'b1;
    if (crit && ce)                  v = 20'h00A00;
    else if (bk)                     v = 20'h01300;
    else if (im)                     v = 20'h01000;
    else if (lm)                     v = 20'h01100;
    else if (sm || (sh && !chg))     v = 20'h01200;
    else if (pc_cause != 0) begin    v = 20'h00700; c = pc_cause; end
    else if (fop && !fpa)            v = 20'h00800;
    else if (sc)                     v = 20'h00C00;
    else if ((m_pend || rise) && ee) begin v = 20'h00900; dec_taken = 1'b1; end
    else if (pmo)                    v = 20'h00F00;
    else if (cmp && (st_step || (br && brt))) v = 20'h00D00;
    else begin tk = 1'b0; v = 20'h0; end
  endtask

  task automatic check(input string tag, input logic [25:0] act, input logic [25:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act take=%0b vec=%05h cause=%h een=%0b exp take=%0b vec=%05h cause=%h een=%0b",
               tag, act[25], act[24:5], act[4:1], act[0], exp[25], exp[24:5], exp[4:1], exp[0]);
    end
  endtask

  // inputs already applied just after a rising edge
  task automatic run_cycle(input string tag);
    logic tk, dt;
    logic [19:0] v;
    logic [3:0] c;
    #3;
    model(tk, v, c, dt);
    check(tag, {take, vec, cause, een}, {tk, v, c, ee & ~tk});
    m_pend = (m_pend | (dmsb & ~m_prev)) & ~dt & ~dclr;
    m_prev = dmsb;
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    #10;
    check("R13 reset", {take, vec, cause, een}, 26'h0);
    @(posedge clk); #1 rst_ni = 1;
    @(posedge clk); #1;

    // R13 idle after reset
    run_cycle("R13");
    // R7 critical gated and first
    crit = 1; ce = 0; run_cycle("R7 disabled");
    ce = 1; im = 1; sc = 1; run_cycle("R7 over others");
    idle();
    // R10 store hit with clean page, and dirty page
    sh = 1; chg = 0; run_cycle("R10 clean hit");
    chg = 1; run_cycle("R10 dirty hit");
    idle();
    // R3 special-register move in user mode, and in supervisor mode
    smv = 1; shi = 1; usr = 1; run_cycle("R3 spr user");
    usr = 0; run_cycle("R3 spr sup");
    idle();
    // R2 multiple sub-causes
    ill = 1; trp = 1; fpd = 1; fsum = 1; fmode = 2'b10; run_cycle("R2 multi cause");
    fmode = 2'b00; ill = 0; trp = 0; run_cycle("R2 mode off");
    idle();
    // R4 floating point unavailable
    fop = 1; fpa = 0; run_cycle("R4 unavail");
    fpa = 1; run_cycle("R4 avail");
    idle();
    // R9 breakpoints: enable off then on, second slot
    baddr = {30'h0ABCDEF1, 30'h01234567}; pc = 30'h0ABCDEF1; ben = 2'b01;
    run_cycle("R9 disabled");
    ben = 2'b10; run_cycle("R9 slot1");
    pc = 30'h0ABCDEF0; run_cycle("R9 mismatch");
    idle();
    // R8 branch trace
    cmp = 1; br = 1; brt = 1; run_cycle("R8 branch");
    br = 0; run_cycle("R8 no branch");
    idle();
    // R5 R6 decrementer edge latched while disabled, then taken
    dmsb = 1; ee = 0; run_cycle("R5 disabled");
    run_cycle("R6 held");
    ee = 1; run_cycle("R6 taken");
    run_cycle("R5 no new edge");
    dmsb = 0; run_cycle("R5 low");
    dmsb = 1; ee = 0; run_cycle("R5 edge again");
    dclr = 1; run_cycle("R6 clear");
    dclr = 0; ee = 1; run_cycle("R6 after clear");
    // R11 R12 direct pulses
    idle(); ee = 1; pmo = 1; run_cycle("R12 pm R11");
    pmo = 0; lm = 1; run_cycle("R12 load miss");
    idle(); dmsb = 0; run_cycle("R13 quiet");

    // random traffic, R1 priority
    for (int i = 0; i < 4000; i++) begin
      ee = $urandom_range(0, 1); ce = $urandom_range(0, 1); usr = $urandom_range(0, 1);
      fpa = $urandom_range(0, 1); st_step = ($urandom_range(0, 3) == 0);
      brt = $urandom_range(0, 1); fsum = $urandom_range(0, 1); fmode = 2'($urandom);
      fpd = ($urandom_range(0, 9) == 0); ill = ($urandom_range(0, 19) == 0);
      trp = ($urandom_range(0, 19) == 0); pop = ($urandom_range(0, 9) == 0);
      smv = ($urandom_range(0, 9) == 0); shi = $urandom_range(0, 1);
      fop = ($urandom_range(0, 9) == 0); sc = ($urandom_range(0, 14) == 0);
      cmp = ($urandom_range(0, 2) == 0); br = $urandom_range(0, 1);
      pmo = ($urandom_range(0, 14) == 0); im = ($urandom_range(0, 19) == 0);
      lm = ($urandom_range(0, 19) == 0); sm = ($urandom_range(0, 19) == 0);
      sh = ($urandom_range(0, 9) == 0); chg = $urandom_range(0, 1);
      crit = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 5) == 0) dmsb = ~dmsb;
      dclr = ($urandom_range(0, 29) == 0);
      baddr = {30'($urandom), 30'($urandom)}; ben = 2'($urandom);
      case ($urandom_range(0, 9))
        0: pc = baddr[WA-1:0];
        1: pc = baddr[2*WA-1:WA];
        default: pc = 30'($urandom);
      endcase
      run_cycle("R1 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule